// File: doc/BRIEF.md
# Shared-Bus Accumulator Register Datapath

This block is the register side of a small accumulator machine. Six registers sit around one 16-bit shared bus, together with a 4096-word by 16-bit memory array. The registers are an address register, a program counter, a data register, an accumulator, an instruction register and a temporary register. A 3-bit select input decides which source drives the bus. Every register has its own clear, load and increment strobes. The memory is read onto the bus, or written from the bus, at the word addressed by the address register.

The accumulator never loads from the bus. It always takes the result of a small arithmetic/logic unit, and a carry flag sits beside it. This is why the accumulator and the data register can swap contents in one clock: the bus carries the accumulator to the data register, and the unit passes the data register to the accumulator.

All strobes come from an external sequencer, and every transfer takes effect on the rising clock edge. A separate preload port fills the memory before a program runs.

Top module: `busreg_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the address register, program counter, data register, accumulator, instruction register, temporary register and carry flag to zero on the next rising edge.
- R2: `bus_sel` selects the bus source: 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register, 7 the memory word at the address register. The 12-bit sources are zero-extended to 16 bits.
- R3: Strobe vectors `reg_ld`, `reg_inc` and `reg_clr` use bit 0 for the address register, 1 for the program counter, 2 for the data register, 3 for the accumulator, 4 for the instruction register and 5 for the temporary register. A set load bit copies the bus into that register at the edge; the two 12-bit registers take only bus bits [11:0]. Several registers may load the same bus value at once.
- R4: Within one register, clear beats load and load beats increment. Increment adds one and wraps at the register's width (0xFFF to 0 for the 12-bit registers).
- R5: In a cycle where every strobe, `mem_wr` and `pre_we` are low, no register, the carry flag and the memory all hold their values.
- R6: `mem_wr` stores the bus value into the memory word addressed by the address register at the edge. It can be combined with register loads in the same cycle.
- R7: A load of the accumulator writes the unit's result, chosen by `alu_op`: 0 passes the data register, 1 adds the accumulator and the data register (the low 16 bits go to the accumulator and the carry out to the flag, so 0x7EC3 + 0x8B9F gives 0x0A62 with a carry of 1), 2 ANDs them, 3 complements the accumulator. The flag changes only on an unsuppressed accumulator load with `alu_op` = 1.
- R8: With `bus_sel` = 4, the data register load bit set, and the accumulator load bit set with `alu_op` = 0, the two registers exchange their contents in a single clock.
- R9: `pre_we` writes `pre_data` into memory word `pre_addr` at the edge. When it is high in the same cycle as `mem_wr`, the preload write takes effect and the datapath write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source select |
| reg_ld | input | 6 | Per-register load strobes |
| reg_inc | input | 6 | Per-register increment strobes |
| reg_clr | input | 6 | Per-register clear strobes |
| alu_op | input | 2 | Accumulator function select |
| mem_wr | input | 1 | Write the bus value into memory at the address register |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 12 | Preload word address |
| pre_data | input | 16 | Preload word value |
| bus | output | 16 | Current bus value |
| ar | output | 12 | Address register |
| pc | output | 12 | Program counter |
| dr | output | 16 | Data register |
| ac | output | 16 | Accumulator |
| ir | output | 16 | Instruction register |
| tr | output | 16 | Temporary register |
| e | output | 1 | Carry flag |

## Verification
The properties assume that every strobe and select input is a known value after reset. They also assume that no memory word is read before something has written it, since reading an unwritten word puts an unknown value on the bus and into any register that loads it. To stay inside these limits, the stimulus drives only defined values and preloads every memory word through the preload port before any directed or random cycle selects the memory. The random phase draws its clear strobes with low probability, so that load, increment, the unit's functions and the memory write interact often before a clear wipes a register.

// File: rtl/busreg_pkg.sv
package busreg_pkg;
   localparam int NREG  = 6;
   localparam int RI_AR = 0;
   localparam int RI_PC = 1;
   localparam int RI_DR = 2;
   localparam int RI_AC = 3;
   localparam int RI_IR = 4;
   localparam int RI_TR = 5;
   localparam int SEL_W = $clog2(NREG + 2);
   localparam logic [SEL_W-1:0] SEL_NONE = '0;
   localparam logic [SEL_W-1:0] SEL_MEM  = SEL_W'(NREG + 1);
   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_AND  = 2'd2,
      ALU_NOT  = 2'd3
   } alu_op_e;
endpackage

// File: rtl/busreg_cell.sv
module busreg_cell #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         ld,
   input  logic         inc,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (W >= 1) else $error("busreg_cell: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst || clr)
         q <= '0;
      else if (ld)
         q <= d;
      else if (inc)
         q <= q + W'(1);
   end
endmodule

// File: rtl/busreg_alu.sv
module busreg_alu import busreg_pkg::*; #(
   parameter int DATA_W = 16
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] y,
   output logic              cout
);
   logic [DATA_W:0] sum;

   always_comb begin
      sum  = {1'b0, acc} + {1'b0, opnd};
      cout = sum[DATA_W];
      unique case (op)
         ALU_PASS: y = opnd;
         ALU_ADD:  y = sum[DATA_W-1:0];
         ALU_AND:  y = acc & opnd;
         ALU_NOT:  y = ~acc;
         default:  y = opnd;
      endcase
   end
endmodule

// File: rtl/busreg_mem.sv
module busreg_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   initial begin
      assert (ADDR_W <= 13) else $error("busreg_mem: array too deep");
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];
endmodule

// File: rtl/busreg_busmux.sv
module busreg_busmux import busreg_pkg::*; #(
   parameter int DATA_W = 16
) (
   input  logic [SEL_W-1:0]            sel,
   input  logic [NREG-1:0][DATA_W-1:0] regs,
   input  logic [DATA_W-1:0]           mem_word,
   output logic [DATA_W-1:0]           bus
);
   always_comb begin
      if (sel == SEL_NONE)
         bus = '0;
      else if (sel == SEL_MEM)
         bus = mem_word;
      else
         bus = regs[int'(sel) - 1];
   end
endmodule

// File: rtl/busreg_datapath.sv
module busreg_datapath import busreg_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  bus_sel,
   input  logic [NREG-1:0]   reg_ld,
   input  logic [NREG-1:0]   reg_inc,
   input  logic [NREG-1:0]   reg_clr,
   input  logic [1:0]        alu_op,
   input  logic              mem_wr,
   input  logic              pre_we,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   output logic [DATA_W-1:0] bus,
   output logic [ADDR_W-1:0] ar,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] dr,
   output logic [DATA_W-1:0] ac,
   output logic [DATA_W-1:0] ir,
   output logic [DATA_W-1:0] tr,
   output logic              e
);
   initial begin
      assert (DATA_W >= 2) else $error("busreg_datapath: DATA_W too small");
      assert (ADDR_W >= 1 && ADDR_W <= DATA_W)
         else $error("busreg_datapath: ADDR_W must fit in the bus");
   end

   logic [NREG-1:0][DATA_W-1:0] regq;
   logic [DATA_W-1:0]           alu_y;
   logic                        alu_c;
   logic [DATA_W-1:0]           mem_rdata;
   logic                        mem_wen;
   logic [ADDR_W-1:0]           mem_waddr;
   logic [DATA_W-1:0]           mem_wdata;
   alu_op_e                     op_q;

   assign op_q = alu_op_e'(alu_op);

   // register file around the bus; address-sized registers are narrower
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int W = (i == RI_AR || i == RI_PC) ? ADDR_W : DATA_W;
      logic [W-1:0] d;
      logic [W-1:0] q;
      if (i == RI_AC) begin : g_from_alu
         assign d = W'(alu_y);
      end else begin : g_from_bus
         assign d = bus[W-1:0];
      end
      busreg_cell #(.W(W)) u_cell (
         .clk (clk),
         .rst (rst),
         .clr (reg_clr[i]),
         .ld  (reg_ld[i]),
         .inc (reg_inc[i]),
         .d   (d),
         .q   (q)
      );
      assign regq[i] = DATA_W'(q);
   end

   busreg_busmux #(.DATA_W(DATA_W)) u_mux (
      .sel      (bus_sel),
      .regs     (regq),
      .mem_word (mem_rdata),
      .bus      (bus)
   );

   busreg_alu #(.DATA_W(DATA_W)) u_alu (
      .op   (op_q),
      .acc  (regq[RI_AC]),
      .opnd (regq[RI_DR]),
      .y    (alu_y),
      .cout (alu_c)
   );

   // preload port has precedence over the datapath write
   assign mem_wen   = pre_we | mem_wr;
   assign mem_waddr = pre_we ? pre_addr : regq[RI_AR][ADDR_W-1:0];
   assign mem_wdata = pre_we ? pre_data : bus;

   busreg_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk     (clk),
      .wr_en   (mem_wen),
      .wr_addr (mem_waddr),
      .wr_data (mem_wdata),
      .rd_addr (regq[RI_AR][ADDR_W-1:0]),
      .rd_data (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst)
         e <= 1'b0;
      else if (reg_ld[RI_AC] && !reg_clr[RI_AC] && op_q == ALU_ADD)
         e <= alu_c;
   end

   assign ar = regq[RI_AR][ADDR_W-1:0];
   assign pc = regq[RI_PC][ADDR_W-1:0];
   assign dr = regq[RI_DR];
   assign ac = regq[RI_AC];
   assign ir = regq[RI_IR];
   assign tr = regq[RI_TR];
endmodule

// File: rtl/busreg_datapath_chk.sv
module busreg_datapath_chk import busreg_pkg::*; #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic [SEL_W-1:0]  bus_sel,
   input logic [NREG-1:0]   reg_ld,
   input logic [NREG-1:0]   reg_inc,
   input logic [NREG-1:0]   reg_clr,
   input logic [1:0]        alu_op,
   input logic              mem_wr,
   input logic              pre_we,
   input logic [DATA_W-1:0] bus,
   input logic [ADDR_W-1:0] ar,
   input logic [ADDR_W-1:0] pc,
   input logic [DATA_W-1:0] dr,
   input logic [DATA_W-1:0] ac,
   input logic [DATA_W-1:0] ir,
   input logic [DATA_W-1:0] tr,
   input logic              e
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (ar == '0 && pc == '0 && dr == '0 && ac == '0 &&
                      ir == '0 && tr == '0 && !e));

   // R2
   always_comb begin
      if (rst == 1'b0 && bus_sel == SEL_NONE)
         sel_none_chk: assert (bus == '0);
      if (rst == 1'b0 && bus_sel == 3'd2)
         sel_pc_chk: assert (bus == DATA_W'(pc));
   end

   // R3
   dr_load_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_ld[RI_DR] && !reg_clr[RI_DR]) |=> dr == $past(bus));

   // R4
   tr_clear_chk: assert property (@(posedge clk) disable iff (rst)
      reg_clr[RI_TR] |=> tr == '0);

   // R4
   pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_inc[RI_PC] && !reg_ld[RI_PC] && !reg_clr[RI_PC]) |=>
         pc == $past(pc) + ADDR_W'(1));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_ld == '0 && reg_inc == '0 && reg_clr == '0) |=>
         ($stable(ar) && $stable(pc) && $stable(dr) && $stable(ac) &&
          $stable(ir) && $stable(tr) && $stable(e)));

   // R7
   add_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_ld[RI_AC] && !reg_clr[RI_AC] && alu_op == 2'd1) |=>
         {e, ac} == {1'b0, $past(ac)} + {1'b0, $past(dr)});

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(reg_ld[RI_AC] && !reg_clr[RI_AC] && alu_op == 2'd1) |=> $stable(e));

   // R8
   swap_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_sel == 3'd4 && reg_ld[RI_DR] && reg_ld[RI_AC] && reg_clr == '0 &&
       alu_op == 2'd0) |=> (ac == $past(dr) && dr == $past(ac)));
endmodule

bind busreg_datapath busreg_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .bus_sel (bus_sel),
   .reg_ld  (reg_ld),
   .reg_inc (reg_inc),
   .reg_clr (reg_clr),
   .alu_op  (alu_op),
   .mem_wr  (mem_wr),
   .pre_we  (pre_we),
   .bus     (bus),
   .ar      (ar),
   .pc      (pc),
   .dr      (dr),
   .ac      (ac),
   .ir      (ir),
   .tr      (tr),
   .e       (e)
);

// File: tb/busreg_datapath_test.sv
`timescale 1ns/1ps
module busreg_datapath_test;
   localparam logic [5:0] B_AR = 6'b000001;
   localparam logic [5:0] B_PC = 6'b000010;
   localparam logic [5:0] B_DR = 6'b000100;
   localparam logic [5:0] B_AC = 6'b001000;
   localparam logic [5:0] B_IR = 6'b010000;
   localparam logic [5:0] B_TR = 6'b100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  bus_sel = '0;
   logic [5:0]  reg_ld = '0, reg_inc = '0, reg_clr = '0;
   logic [1:0]  alu_op = '0;
   logic        mem_wr = 1'b0, pre_we = 1'b0;
   logic [11:0] pre_addr = '0;
   logic [15:0] pre_data = '0;
   logic [15:0] bus, dr, ac, ir, tr;
   logic [11:0] ar, pc;
   logic        e;

   int checks = 0;
   int fails  = 0;

   // bench model state
   logic [11:0] m_ar = '0, m_pc = '0;
   logic [15:0] m_dr = '0, m_ac = '0, m_ir = '0, m_tr = '0;
   logic        m_e = 1'b0;
   logic [15:0] mm [4096];

   always #10 clk = ~clk;

   busreg_datapath uut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .reg_ld(reg_ld),
      .reg_inc(reg_inc), .reg_clr(reg_clr), .alu_op(alu_op),
      .mem_wr(mem_wr), .pre_we(pre_we), .pre_addr(pre_addr),
      .pre_data(pre_data), .bus(bus), .ar(ar), .pc(pc), .dr(dr),
      .ac(ac), .ir(ir), .tr(tr), .e(e)
   );

   task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [15:0] exp_bus(input logic [2:0] s);
      case (s)
         3'd1: return {4'h0, m_ar};
         3'd2: return {4'h0, m_pc};
         3'd3: return m_dr;
         3'd4: return m_ac;
         3'd5: return m_ir;
         3'd6: return m_tr;
         3'd7: return mm[m_ar];
         default: return 16'h0000;
      endcase
   endfunction

   function automatic logic [16:0] exp_alu(input logic [1:0] op);
      logic [16:0] s;
      s = {1'b0, m_ac} + {1'b0, m_dr};
      case (op)
         2'd0: return {m_e, m_dr};
         2'd1: return s;
         2'd2: return {m_e, m_ac & m_dr};
         default: return {m_e, ~m_ac};
      endcase
   endfunction

   function automatic logic [15:0] nxt16(input logic [15:0] cur, input logic [15:0] d,
                                         input logic c, input logic l, input logic i);
      if (c) return 16'h0;
      if (l) return d;
      if (i) return cur + 16'd1;
      return cur;
   endfunction

   function automatic logic [11:0] nxt12(input logic [11:0] cur, input logic [11:0] d,
                                         input logic c, input logic l, input logic i);
      if (c) return 12'h0;
      if (l) return d;
      if (i) return cur + 12'd1;
      return cur;
   endfunction

   // one clock: drive inputs, check bus, advance model, compare registers
   task automatic step(input logic [2:0] s, input logic [5:0] l, input logic [5:0] i,
                       input logic [5:0] c, input logic [1:0] op, input logic mw,
                       input logic pw, input logic [11:0] pa, input logic [15:0] pd,
                       input string tag);
      logic [15:0] eb;
      logic [16:0] al;
      logic [11:0] n_ar, n_pc;
      logic [15:0] n_dr, n_ac, n_ir, n_tr;
      logic        n_e;
      bus_sel = s; reg_ld = l; reg_inc = i; reg_clr = c; alu_op = op;
      mem_wr = mw; pre_we = pw; pre_addr = pa; pre_data = pd;
      #1;
      eb = exp_bus(s);
      chk({tag, " R2 bus"}, 128'(bus), 128'(eb));
      al   = exp_alu(op);
      n_ar = nxt12(m_ar, eb[11:0], c[0], l[0], i[0]);
      n_pc = nxt12(m_pc, eb[11:0], c[1], l[1], i[1]);
      n_dr = nxt16(m_dr, eb, c[2], l[2], i[2]);
      n_ac = nxt16(m_ac, al[15:0], c[3], l[3], i[3]);
      n_ir = nxt16(m_ir, eb, c[4], l[4], i[4]);
      n_tr = nxt16(m_tr, eb, c[5], l[5], i[5]);
      n_e  = (l[3] && !c[3] && op == 2'd1) ? al[16] : m_e;
      if (pw) mm[pa] = pd;
      else if (mw) mm[m_ar] = eb;
      @(posedge clk);
      #5;
      m_ar = n_ar; m_pc = n_pc; m_dr = n_dr; m_ac = n_ac;
      m_ir = n_ir; m_tr = n_tr; m_e = n_e;
      chk({tag, " R3 R4 registers"}, 128'({ar, pc, dr, ac, ir, tr, e}),
          128'({m_ar, m_pc, m_dr, m_ac, m_ir, m_tr, m_e}));
   endtask

   task automatic idle(input string tag);
      step(3'd0, 6'h0, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, tag);
   endtask

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      @(posedge clk); @(posedge clk);
      #5;
      // R1 reset state
      chk("R1 reset", 128'({ar, pc, dr, ac, ir, tr, e}), 128'(0));
      rst = 1'b0;

      // fill memory through the preload port (R9)
      for (int a = 0; a < 4096; a++)
         step(3'd0, 6'h0, 6'h0, 6'h0, 2'd0, 1'b0, 1'b1, 12'(a),
              16'(a * 40503) ^ 16'h5A5A, "R9 preload");
      step(3'd0, 6'h0, 6'h0, 6'h0, 2'd0, 1'b0, 1'b1, 12'h000, 16'h7EC3, "R9 preload");
      step(3'd0, 6'h0, 6'h0, 6'h0, 2'd0, 1'b0, 1'b1, 12'h001, 16'h8B9F, "R9 preload");
      step(3'd0, 6'h0, 6'h0, 6'h0, 2'd0, 1'b0, 1'b1, 12'h002, 16'hFFFF, "R9 preload");

      // directed: add with carry (R7)
      step(3'd7, B_DR, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R3 mem to DR");
      chk("R3 DR from memory", 128'(dr), 128'(16'h7EC3));
      step(3'd0, B_AC, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R7 pass");
      chk("R7 pass DR", 128'(ac), 128'(16'h7EC3));
      step(3'd0, 6'h0, B_AR, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R4 inc AR");
      step(3'd7, B_DR, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R3 mem to DR");
      step(3'd0, B_AC, 6'h0, 6'h0, 2'd1, 1'b0, 1'b0, 12'h0, 16'h0, "R7 add");
      chk("R7 add sum", 128'({e, ac}), 128'({1'b1, 16'h0A62}));

      // R8 exchange
      step(3'd4, B_DR | B_AC, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R8 swap");
      chk("R8 swap", 128'({ac, dr}), 128'({16'h8B9F, 16'h0A62}));

      // R6 write and load together, then read back
      step(3'd4, B_DR, 6'h0, 6'h0, 2'd0, 1'b1, 1'b0, 12'h0, 16'h0, "R6 write");
      chk("R6 DR with write", 128'(dr), 128'(16'h8B9F));
      step(3'd0, B_AC, 6'h0, 6'h0, 2'd3, 1'b0, 1'b0, 12'h0, 16'h0, "R7 not");
      step(3'd4, 6'h0, 6'h0, 6'h0, 2'd0, 1'b1, 1'b0, 12'h0, 16'h0, "R6 write");
      step(3'd7, B_TR, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R6 read");
      chk("R6 read back", 128'(tr), 128'(16'h7460));

      // R3 truncation, R2 zero-extension, R4 wrap and priority
      step(3'd0, 6'h0, B_AR, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R4 inc AR");
      step(3'd7, B_PC, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R3 trunc");
      chk("R3 PC low bits", 128'(pc), 128'(12'hFFF));
      bus_sel = 3'd2; #1;
      chk("R2 zero extend", 128'(bus), 128'(16'h0FFF));
      step(3'd0, 6'h0, B_PC, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R4 wrap");
      chk("R4 PC wrap", 128'(pc), 128'(12'h000));
      step(3'd7, B_PC, B_PC, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R4 ld over inc");
      chk("R4 load beats inc", 128'(pc), 128'(12'hFFF));
      step(3'd7, B_PC, B_PC, B_PC, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R4 clr first");
      chk("R4 clear beats load", 128'(pc), 128'(12'h000));

      // R5 idle
      idle("R5 idle");
      chk("R5 hold", 128'({ar, dr, ac, tr, e}),
          128'({12'h002, 16'h8B9F, 16'h7460, 16'h7460, 1'b1}));

      // R9 preload beats datapath write
      step(3'd4, 6'h0, 6'h0, 6'h0, 2'd0, 1'b1, 1'b1, 12'h002, 16'h1234, "R9 collide");
      step(3'd7, B_IR, 6'h0, 6'h0, 2'd0, 1'b0, 1'b0, 12'h0, 16'h0, "R9 read");
      chk("R9 preload wins", 128'(ir), 128'(16'h1234));

      // random phase
      for (int n = 0; n < 2000; n++) begin
         logic [5:0] rc;
         rc = 6'($urandom) & 6'($urandom) & 6'($urandom);
         step(3'($urandom), 6'($urandom), 6'($urandom), rc, 2'($urandom),
              ($urandom % 4) == 0, 1'b0, 12'h0, 16'h0, "R7 random");
      end

      // R1 reset from a busy state
      rst = 1'b1;
      reg_ld = 6'h3F; reg_inc = 6'h3F; bus_sel = 3'd7;
      @(posedge clk); #5;
      chk("R1 reset again", 128'({ar, pc, dr, ac, ir, tr, e}), 128'(0));

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule